// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a synthesizable model of an asynchronous 16-bit static RAM with a reduced depth. A fast sampling clock drives it, so it can stand in for the real memory when the external-memory controller it serves is being checked. The model has two byte lanes, and each lane has its own active-low enable. The bidirectional data bus is split into three parts: an input word, an output word, and a per-lane drive enable. The drive enable shows which lanes the memory would be driving onto the shared bus.

On every sampling edge, the five active-low strobes are decoded into one of four modes. The modes are held in a small state machine:
- `ST_IDLE` means deselected, either because chip select is high or because both lanes are off while write enable is high.
- `ST_OFF` means selected with outputs disabled.
- `ST_READ` is a read.
- `ST_WRITE` is the write window, where chip select and write enable are both low.

The transitions out of `ST_WRITE` are named `end_of_write`, and they commit the captured word. Every other transition is a direct move to the newly decoded mode (`select`, `deselect`, `open_read`, `close_read`, `open_write`). The register commits no data on those transitions.

While the window is open, the model captures the address, data and lane enables on every edge. When the window closes, whichever strobe closed it, the last captured values are written through the lane mask. Two monitors count the length of each write window and each continuous read stretch. A stretch that is shorter than its parameterised minimum sets a sticky violation flag.

Top module: `byte_sram_model`

## Requirements
- R1: While `ce_n` is high, `drive_en` is 2'b00 and `dout` is zero, whatever the other strobes are, and no write takes place even with `we_n` low.
- R2: With `ce_n` low and both `ub_n` and `lb_n` high, `drive_en` is 2'b00, and a window with `we_n` low stores nothing.
- R3: With `ce_n` low, `we_n` high and `oe_n` low, `drive_en[0]` equals `~lb_n` and `drive_en[1]` equals `~ub_n`. On each driven lane, `dout` carries that lane of the stored word (bits 7:0 for the low lane, 15:8 for the high lane). An undriven lane reads zero.
- R4: With `ce_n` low, `we_n` high and `oe_n` high, `drive_en` is 2'b00.
- R5: With `ce_n` and `we_n` both low, `drive_en` is 2'b00 whatever `oe_n` is.
- R6: A write stores the `din` and address sampled on the last edge on which `ce_n` and `we_n` were both low. Only the lanes whose enables were low on that edge are written. The new word is readable from the first edge that sees the window closed.
- R7: When `ce_n` and `we_n` rise together to end a write, the write commits and `drive_en` stays 2'b00.
- R8: Address bits at and above log2(`DEPTH`) are ignored, so `addr` and `addr + DEPTH` name the same word.
- R9: A write window that lasts fewer than `MIN_WE_CYC` sampling edges sets `viol` on the edge that sees it close. `viol` then stays high until reset.
- R10: A continuous read stretch that lasts fewer than `MIN_RD_CYC` sampling edges sets `viol` on the edge that sees it end.
- R11: Reset clears every word to zero and clears `viol`.
- R12: A write with one lane enabled leaves the other lane of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, clears storage and flag |
| addr | input | ADDR_W | Word address, upper bits ignored |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | High-lane enable, active low |
| lb_n | input | 1 | Low-lane enable, active low |
| din | input | 16 | Data arriving from the bus |
| dout | output | 16 | Read data, zero on undriven lanes |
| drive_en | output | 2 | Per-lane bus drive, bit 1 high lane |
| viol | output | 1 | Sticky strobe-width violation |

## Verification
The drive enables and read data follow the present strobes and address with no register in the path. The bench therefore checks them half a clock after each input change, in the same cycle.

A committed write depends on one register: the previous-mode state. Its effect is first visible in the cycle after the edge that sees the window closed. The violation flag is set by that same closing edge.

The reference model in the bench updates its memory, its capture registers and its pulse counters at the rising edge. It compares all outputs at the falling edge, so every expected value carries the same one-edge lag as the design.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFF   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } sram_mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
    import sram_model_pkg::*;
(
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       ub_n,
    input  logic       lb_n,
    output sram_mode_e mode
);
    always_comb begin
        if (ce_n)
            mode = ST_IDLE;
        else if (!we_n)
            mode = ST_WRITE;
        else if (ub_n && lb_n)
            mode = ST_IDLE;
        else if (oe_n)
            mode = ST_OFF;
        else
            mode = ST_READ;
    end
endmodule

// File: rtl/sram_pulse_mon.sv
module sram_pulse_mon #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic short_end
);
    localparam int CW = $clog2(MIN_CYC + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active)
            cnt_q <= '0;
        else if (cnt_q < LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign short_end = !active && (cnt_q != '0) && (cnt_q < LIMIT);
endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_model_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    cells[i] <= '0;
            end else if (wr && lane_wr[l]) begin
                cells[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/byte_sram_model.sv
module byte_sram_model
    import sram_model_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int ADDR_W     = 18,
    parameter int MIN_WE_CYC = 3,
    parameter int MIN_RD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  drive_en,
    output logic              viol
);
    localparam int AW = $clog2(DEPTH);

    sram_mode_e        mode_now;
    sram_mode_e        st_q;
    logic [AW-1:0]     idx;
    logic [LANES-1:0]  lane_on;
    logic [AW-1:0]     cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [LANES-1:0]  cap_lanes;
    logic              end_of_write;
    logic [DATA_W-1:0] rd_word;
    logic              we_short;
    logic              rd_short;

    assign idx     = addr[AW-1:0];
    assign lane_on = {~ub_n, ~lb_n};

    sram_mode_dec u_dec (
        .ce_n (ce_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .ub_n (ub_n),
        .lb_n (lb_n),
        .mode (mode_now)
    );

    // state register: previous sampled mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= mode_now;
    end

    assign end_of_write = (st_q == ST_WRITE) && (mode_now != ST_WRITE);

    // capture while the write window is open; last capture wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_data  <= '0;
            cap_lanes <= '0;
        end else if (mode_now == ST_WRITE) begin
            cap_addr  <= idx;
            cap_data  <= din;
            cap_lanes <= lane_on;
        end
    end

    sram_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (end_of_write),
        .lane_wr (cap_lanes),
        .waddr   (cap_addr),
        .wdata   (cap_data),
        .raddr   (idx),
        .rdata   (rd_word)
    );

    sram_pulse_mon #(.MIN_CYC(MIN_WE_CYC)) u_we_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_now == ST_WRITE),
        .short_end (we_short)
    );

    sram_pulse_mon #(.MIN_CYC(MIN_RD_CYC)) u_rd_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_now == ST_READ),
        .short_end (rd_short)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            viol <= 1'b0;
        else if (we_short || rd_short)
            viol <= 1'b1;
    end

    // output process: bus drive per lane from the decoded mode
    always_comb begin
        drive_en = '0;
        unique case (mode_now)
            ST_IDLE:  drive_en = '0;
            ST_OFF:   drive_en = '0;
            ST_READ:  drive_en = lane_on;
            ST_WRITE: drive_en = '0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign dout[l*LANE_W +: LANE_W] =
            drive_en[l] ? rd_word[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_model_checker.sv
module sram_model_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       ub_n,
    input logic       lb_n,
    input logic [1:0] drive_en,
    input logic       viol
);
    AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> drive_en == 2'b00); // R1
    AST_NO_LANE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ub_n && lb_n) |-> drive_en == 2'b00); // R2
    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |-> drive_en == {~ub_n, ~lb_n}); // R3
    AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |-> drive_en == 2'b00); // R4
    AST_WRITE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> drive_en == 2'b00); // R5
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol); // R9
endmodule

bind byte_sram_model sram_model_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .ub_n     (ub_n),
    .lb_n     (lb_n),
    .drive_en (drive_en),
    .viol     (viol)
);

// File: tb/sim_byte_sram_model.sv
module sim_byte_sram_model;
    localparam int DEPTH  = 1024;
    localparam int ADDR_W = 18;
    localparam int MIN_WE = 3;
    localparam int MIN_RD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  drive_en;
    logic        viol;

    always #10 clk = ~clk;

    byte_sram_model #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MIN_WE_CYC(MIN_WE), .MIN_RD_CYC(MIN_RD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .din(din),
        .dout(dout), .drive_en(drive_en), .viol(viol)
    );

    // behavioural reference
    logic [15:0] ref_mem [DEPTH];
    bit          ref_win_prev;
    int          ref_cap_addr;
    logic [15:0] ref_cap_data;
    logic [1:0]  ref_cap_lanes;
    int          ref_we_len, ref_rd_len;
    bit          ref_viol;

    int vectors = 0;
    int errors  = 0;
    string req = "R11";
    bit done = 0;

    function automatic bit ref_reading();
        return !ce_n && we_n && !oe_n && !(ub_n && lb_n);
    endfunction

    task automatic ref_edge();
        bit win;
        bit rd;
        win = !ce_n && !we_n;
        rd  = ref_reading();
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
            ref_win_prev = 0; ref_we_len = 0; ref_rd_len = 0; ref_viol = 0;
            ref_cap_addr = 0; ref_cap_data = '0; ref_cap_lanes = '0;
            return;
        end
        if (ref_win_prev && !win) begin
            if (ref_cap_lanes[0]) ref_mem[ref_cap_addr][7:0]  = ref_cap_data[7:0];
            if (ref_cap_lanes[1]) ref_mem[ref_cap_addr][15:8] = ref_cap_data[15:8];
        end
        if (win) begin
            ref_cap_addr  = int'(addr) % DEPTH;
            ref_cap_data  = din;
            ref_cap_lanes = {~ub_n, ~lb_n};
        end
        if (!win && ref_we_len > 0 && ref_we_len < MIN_WE) ref_viol = 1;
        if (!rd && ref_rd_len > 0 && ref_rd_len < MIN_RD) ref_viol = 1;
        ref_we_len = win ? ref_we_len + 1 : 0;
        ref_rd_len = rd ? ref_rd_len + 1 : 0;
        ref_win_prev = win;
    endtask

    task automatic compare();
        logic [1:0]  exp_drv;
        logic [15:0] word;
        logic [15:0] exp_do;
        exp_drv = ref_reading() ? {~ub_n, ~lb_n} : 2'b00;
        word = ref_mem[int'(addr) % DEPTH];
        exp_do = {exp_drv[1] ? word[15:8] : 8'h00, exp_drv[0] ? word[7:0] : 8'h00};
        vectors++;
        if (drive_en !== exp_drv || dout !== exp_do || viol !== ref_viol) begin
            errors++;
            $display("FAIL %s: drive_en=%b dout=%h viol=%b, expected drive_en=%b dout=%h viol=%b",
                     req, drive_en, dout, viol, exp_drv, exp_do, ref_viol);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            ref_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set(input logic c, input logic w, input logic o,
                       input logic u, input logic l,
                       input logic [ADDR_W-1:0] a, input logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; din = d;
        #1;
    endtask

    task automatic do_reset();
        set(1, 1, 1, 1, 1, '0, '0);
        rst_n = 0;
        cyc(2);
        rst_n = 1;
        cyc(1);
    endtask

    initial begin
        req = "R11";
        do_reset();
        set(0, 1, 0, 0, 0, 18'd5, '0);        cyc(3);   // R11 reads zero
        req = "R6";
        set(0, 0, 1, 0, 0, 18'd5, 16'hA1B2);  cyc(3);
        req = "R1";
        set(1, 1, 1, 0, 0, 18'd5, '0);        cyc(1);
        req = "R6";
        set(0, 1, 0, 0, 0, 18'd5, '0);        cyc(3);
        req = "R12";
        set(0, 0, 1, 1, 0, 18'd5, 16'h33CC);  cyc(3);
        req = "R4";
        set(0, 1, 1, 0, 0, 18'd5, '0);        cyc(2);
        req = "R12";
        set(0, 1, 0, 0, 0, 18'd5, '0);        cyc(3);
        req = "R3";
        set(0, 1, 0, 0, 1, 18'd5, '0);        cyc(2);
        set(0, 1, 0, 1, 0, 18'd5, '0);        cyc(2);
        set(1, 1, 1, 1, 1, '0, '0);           cyc(1);
        req = "R5";
        set(0, 0, 0, 0, 0, 18'd7, 16'h1234);  cyc(3);
        set(1, 1, 0, 0, 0, 18'd7, '0);        cyc(1);
        req = "R7";
        set(0, 0, 1, 0, 0, 18'd9, 16'h5678);  cyc(3);
        set(1, 1, 1, 0, 0, 18'd9, '0);        cyc(1);
        set(0, 1, 0, 0, 0, 18'd9, '0);        cyc(3);
        req = "R2";
        set(0, 0, 0, 1, 1, 18'd7, 16'hFFFF);  cyc(3);
        set(0, 1, 0, 1, 1, 18'd7, '0);        cyc(2);
        set(0, 1, 0, 0, 0, 18'd7, '0);        cyc(3);
        req = "R1";
        set(1, 0, 0, 0, 0, 18'd7, 16'h0000);  cyc(3);
        set(0, 1, 0, 0, 0, 18'd7, '0);        cyc(3);
        req = "R8";
        set(0, 0, 1, 0, 0, 18'(3 + DEPTH), 16'hBEEF); cyc(3);
        set(1, 1, 1, 1, 1, '0, '0);           cyc(1);
        set(0, 1, 0, 0, 0, 18'd3, '0);        cyc(3);
        req = "R6";
        set(0, 0, 1, 0, 0, 18'd11, 16'h1111); cyc(1);
        set(0, 0, 1, 0, 0, 18'd12, 16'h2222); cyc(1);
        set(0, 0, 1, 0, 0, 18'd13, 16'h4444); cyc(1);
        set(1, 1, 1, 1, 1, '0, '0);           cyc(1);
        set(0, 1, 0, 0, 0, 18'd13, '0);       cyc(3);
        set(0, 1, 0, 0, 0, 18'd11, '0);       cyc(3);
        req = "R10";
        set(1, 1, 1, 1, 1, '0, '0);           cyc(1);
        set(0, 1, 0, 0, 0, 18'd13, '0);       cyc(2);
        set(1, 1, 1, 1, 1, '0, '0);           cyc(3);
        req = "R11";
        do_reset();
        set(0, 1, 0, 0, 0, 18'd13, '0);       cyc(3);
        req = "R9";
        set(1, 1, 1, 1, 1, '0, '0);           cyc(1);
        set(0, 0, 1, 0, 0, 18'd20, 16'h9999); cyc(1);
        set(1, 1, 1, 1, 1, '0, '0);           cyc(3);
        set(0, 1, 0, 0, 0, 18'd20, '0);       cyc(3);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule